// File: doc/BRIEF.md
# Status Register Write-Protection Unit

This block owns the 8-bit status register of a serial flash controller and decides when the register may be written. A command decoder upstream delivers the instruction bytes of each chip-select frame and a pulse when the frame closes. The unit keeps an arming flag, which is set by the status-arm instruction (50h). It commits a status-write instruction (01h plus one data byte) only when that instruction is the frame that directly follows the arming frame. The hardware lock pin combines with the register's freeze bit to decide whether the commit is refused.

The two zone bits select which upper fraction of the array is guarded. The unit turns them into a protect flag for an address that the program/erase sequencer presents. The busy, write-enable and sequential-program flags are owned by the sequencer. They appear in the register only as read-only mirrors.

Top module: `srwp_top`

## Requirements
- R1: After reset, with busy, write-enable and sequential-program inputs low, `stat_o` reads 8'h0C: zone bits (bits 3:2) are 11 and the freeze bit (bit 7) is 0.
- R2: `stat_o` bit 0 mirrors `busy_i`, bit 1 mirrors `wr_enabled_i` and bit 6 mirrors `seq_prog_i` in the same cycle, and no status write alters them.
- R3: `stat_o` bits 5:4 always read 0, even when a written data byte has them set.
- R4: A status-write frame (first byte 01h, second byte the data) has no effect unless the frame closed just before it had 50h as its first byte.
- R5: The arm is lost when the next frame is anything other than a status write: another opcode, or a frame that closes with no bytes. A status write also consumes the arm, whether or not that write is committed.
- R6: An armed status write with `hw_lock_n_i` high takes data bit 7 as the freeze bit and data bits 3:2 as the zone bits. The new value is visible in the cycle after `frame_end_i`.
- R7: With `hw_lock_n_i` low and the freeze bit 0, an armed status write is committed. One write may set the freeze bit and change the zone bits together.
- R8: With `hw_lock_n_i` low and the freeze bit 1, an armed status write is refused, so the freeze bit cannot be cleared while the pin is low.
- R9: `hw_lock_n_i` is sampled only in the cycle in which `frame_end_i` is high.
- R10: A status-write frame without a data byte writes nothing. Bytes after the first data byte are ignored.
- R11: `query_prot_o` is set when the zone bits are 11 (any address), 10 (upper half of the array) or 01 (upper quarter of the array). It is clear for every address when the zone bits are 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid_i | input | 1 | One instruction byte is present this cycle |
| rx_byte_i | input | 8 | Instruction byte, first byte of a frame is the opcode |
| frame_end_i | input | 1 | Chip select has just been released; the frame is over |
| hw_lock_n_i | input | 1 | Hardware lock pin, low enables the freeze bit |
| busy_i | input | 1 | Operation-in-progress flag from the sequencer |
| wr_enabled_i | input | 1 | Write-enable latch from the sequencer |
| seq_prog_i | input | 1 | Sequential-program mode flag from the sequencer |
| query_addr_i | input | ADDR_W | Byte address to test for protection |
| query_prot_o | output | 1 | The queried address lies in the guarded zone |
| stat_o | output | 8 | Status register read value |

## Verification
Status writes are tried in five framings: without an arm, with an intervening opcode, with an empty frame between, without a data byte, and with extra trailing bytes. This separates a correct one-frame arm window from an arm that lingers or ignores frame boundaries. The lock pin is driven in all four combinations with the freeze bit, and also toggled just before the frame ends. These cases show whether refusal depends on both inputs and on the close-of-frame level. The protect flag is probed on both sides of the half and quarter boundaries for every zone setting, which exposes an off-by-one split or swapped zone codes.

// File: rtl/srwp_pkg.sv
package srwp_pkg;

    localparam logic [7:0] OP_ARM_STAT = 8'h50;
    localparam logic [7:0] OP_WR_STAT  = 8'h01;

    typedef enum logic [1:0] {
        CNT_NONE,
        CNT_OP,
        CNT_DATA,
        CNT_MORE
    } byte_cnt_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } stat_wr_t;

    typedef struct packed {
        logic       freeze;
        logic [1:0] zone;
    } prot_cfg_t;

    localparam prot_cfg_t CFG_RESET = '{freeze: 1'b0, zone: 2'b11};

    // zone code against the two most significant address bits
    function automatic logic zone_hit(input logic [1:0] zone, input logic [1:0] top2);
        case (zone)
            2'b00:   return 1'b0;
            2'b01:   return top2 == 2'b11;
            2'b10:   return top2[1];
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] pack_status(input prot_cfg_t cfg, input logic busy,
                                               input logic wel, input logic seq);
        return {cfg.freeze, seq, 2'b00, cfg.zone, wel, busy};
    endfunction

endpackage

// File: rtl/srwp_cmd_track.sv
module srwp_cmd_track
    import srwp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_byte_i,
    input  logic       frame_end_i,
    output stat_wr_t   wr_req_o
);

    byte_cnt_e  cnt_q;
    logic [7:0] op_q;
    logic [7:0] data_q;
    logic       arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= CNT_NONE;
            op_q   <= '0;
            data_q <= '0;
            arm_q  <= 1'b0;
        end else if (frame_end_i) begin
            cnt_q <= CNT_NONE;
            arm_q <= (cnt_q != CNT_NONE) && (op_q == OP_ARM_STAT);
        end else if (rx_valid_i) begin
            case (cnt_q)
                CNT_NONE: begin
                    op_q  <= rx_byte_i;
                    cnt_q <= CNT_OP;
                end
                CNT_OP: begin
                    data_q <= rx_byte_i;
                    cnt_q  <= CNT_DATA;
                end
                default: cnt_q <= CNT_MORE;
            endcase
        end
    end

    always_comb begin
        wr_req_o.valid = frame_end_i && arm_q && (op_q == OP_WR_STAT)
                         && (cnt_q == CNT_DATA || cnt_q == CNT_MORE);
        wr_req_o.data  = data_q;
    end

    // R5: a status write uses up the arm
    a_r5_arm_consumed: assert property (@(posedge clk) disable iff (rst)
        wr_req_o.valid |=> !arm_q);

    // R10: a frame with no opcode byte never raises a write request
    a_r10_empty_frame_no_req: assert property (@(posedge clk) disable iff (rst)
        (frame_end_i && cnt_q == CNT_NONE) |-> !wr_req_o.valid);

endmodule

// File: rtl/srwp_lock_gate.sv
module srwp_lock_gate
    import srwp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  stat_wr_t  wr_req_i,
    input  logic      hw_lock_n_i,
    output prot_cfg_t cfg_o
);

    prot_cfg_t cfg_q;
    logic      accept;

    assign accept = wr_req_i.valid && (hw_lock_n_i || !cfg_q.freeze);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (accept) begin
            cfg_q.freeze <= wr_req_i.data[7];
            cfg_q.zone   <= wr_req_i.data[3:2];
        end
    end

    assign cfg_o = cfg_q;

    // R8: pin low with freeze set keeps the whole configuration
    a_r8_frozen_holds: assert property (@(posedge clk) disable iff (rst)
        (!hw_lock_n_i && cfg_q.freeze) |=> $stable(cfg_q));

    // R4: without a write request the configuration never moves
    a_r4_no_req_stable: assert property (@(posedge clk) disable iff (rst)
        !wr_req_i.valid |=> $stable(cfg_q));

endmodule

// File: rtl/srwp_zone_decode.sv
module srwp_zone_decode
    import srwp_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [1:0]        zone_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              prot_o
);

    logic [1:0] top2;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign top2 = addr_i[ADDR_W-1 -: 2];
        end else begin : g_narrow
            assign top2 = {addr_i[0], 1'b1};
        end
    endgenerate

    assign prot_o = zone_hit(zone_i, top2);

endmodule

// File: rtl/srwp_top.sv
module srwp_top
    import srwp_pkg::*;
#(
    parameter int ARRAY_BYTES = 131072,
    localparam int ADDR_W = $clog2(ARRAY_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_byte_i,
    input  logic              frame_end_i,
    input  logic              hw_lock_n_i,
    input  logic              busy_i,
    input  logic              wr_enabled_i,
    input  logic              seq_prog_i,
    input  logic [ADDR_W-1:0] query_addr_i,
    output logic              query_prot_o,
    output logic [7:0]        stat_o
);

    stat_wr_t  wr_req;
    prot_cfg_t cfg;

    srwp_cmd_track u_track (
        .clk         (clk),
        .rst         (rst),
        .rx_valid_i  (rx_valid_i),
        .rx_byte_i   (rx_byte_i),
        .frame_end_i (frame_end_i),
        .wr_req_o    (wr_req)
    );

    srwp_lock_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .wr_req_i    (wr_req),
        .hw_lock_n_i (hw_lock_n_i),
        .cfg_o       (cfg)
    );

    srwp_zone_decode #(.ADDR_W(ADDR_W)) u_zone (
        .zone_i (cfg.zone),
        .addr_i (query_addr_i),
        .prot_o (query_prot_o)
    );

    assign stat_o = pack_status(cfg, busy_i, wr_enabled_i, seq_prog_i);

    // R11: zone 00 guards nothing, zone 11 guards everything
    a_r11_zone_none: assert property (@(posedge clk) disable iff (rst)
        (stat_o[3:2] == 2'b00) |-> !query_prot_o);
    a_r11_zone_all: assert property (@(posedge clk) disable iff (rst)
        (stat_o[3:2] == 2'b11) |-> query_prot_o);

    // R6: freeze bit changes only at the end of a frame
    a_r6_change_at_frame_end: assert property (@(posedge clk) disable iff (rst)
        !frame_end_i |=> $stable(stat_o[7]));

endmodule

// File: tb/srwp_top_tb_top.sv
module srwp_top_tb_top;

    localparam int ADDR_W = 17;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rx_valid_i = 1'b0;
    logic [7:0]        rx_byte_i = '0;
    logic              frame_end_i = 1'b0;
    logic              hw_lock_n_i = 1'b1;
    logic              busy_i = 1'b0;
    logic              wr_enabled_i = 1'b0;
    logic              seq_prog_i = 1'b0;
    logic [ADDR_W-1:0] query_addr_i = '0;
    logic              query_prot_o;
    logic [7:0]        stat_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    srwp_top dut_i (.*);

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // one frame of up to three bytes, lock pin held at pin_lvl, frame end, one idle cycle
    task automatic frame(input int n, input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input logic pin_lvl);
        logic [7:0] bs [3];
        bs[0] = b0; bs[1] = b1; bs[2] = b2;
        hw_lock_n_i = pin_lvl;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rx_valid_i = 1'b1; rx_byte_i = bs[i];
        end
        @(negedge clk); rx_valid_i = 1'b0; frame_end_i = 1'b1;
        @(negedge clk); frame_end_i = 1'b0;
    endtask

    task automatic armed_write(input logic [7:0] d, input logic pin_lvl);
        frame(1, 8'h50, 8'h00, 8'h00, pin_lvl);
        frame(2, 8'h01, d, 8'h00, pin_lvl);
    endtask

    task automatic t_reset;
        check("R1 reset value", stat_o, 8'h0C);
    endtask

    task automatic t_mirror;
        busy_i = 1; wr_enabled_i = 1; seq_prog_i = 1;
        #1 check("R2 mirrors set", stat_o, 8'h4F);
        busy_i = 0; wr_enabled_i = 0; seq_prog_i = 0;
        #1 check("R2 mirrors clear", stat_o, 8'h0C);
    endtask

    task automatic t_unarmed;
        frame(2, 8'h01, 8'h00, 8'h00, 1'b1);
        check("R4 unarmed write ignored", stat_o, 8'h0C);
    endtask

    task automatic t_arm_lost;
        frame(1, 8'h50, 0, 0, 1'b1);
        frame(1, 8'h06, 0, 0, 1'b1);
        frame(2, 8'h01, 8'h00, 0, 1'b1);
        check("R5 arm lost after other opcode", stat_o, 8'h0C);
        frame(1, 8'h50, 0, 0, 1'b1);
        frame(0, 0, 0, 0, 1'b1);
        frame(2, 8'h01, 8'h00, 0, 1'b1);
        check("R5 arm lost after empty frame", stat_o, 8'h0C);
    endtask

    task automatic t_write_open;
        armed_write(8'hB7, 1'b1);
        check("R6 R3 write pin high", stat_o, 8'h84);
        busy_i = 1; wr_enabled_i = 1;
        armed_write(8'hFF, 1'b1);
        check("R2 R3 mirrors survive write", stat_o, 8'h8F);
        busy_i = 0; wr_enabled_i = 0;
        armed_write(8'h00, 1'b1);
        check("R6 clear with pin high", stat_o, 8'h00);
        frame(2, 8'h01, 8'h0C, 0, 1'b1);
        check("R5 arm consumed by write", stat_o, 8'h00);
    endtask

    task automatic t_lock;
        armed_write(8'h88, 1'b0);
        check("R7 pin low freeze 0 accepts", stat_o, 8'h88);
        armed_write(8'h00, 1'b0);
        check("R8 pin low freeze 1 refuses", stat_o, 8'h88);
        armed_write(8'h04, 1'b1);
        check("R6 pin high unlocks", stat_o, 8'h04);
    endtask

    task automatic t_pin_sample;
        armed_write(8'h80, 1'b1);
        check("R9 setup", stat_o, 8'h80);
        // pin low during bytes, high only in frame-end cycle
        frame(1, 8'h50, 0, 0, 1'b0);
        hw_lock_n_i = 1'b0;
        @(negedge clk); rx_valid_i = 1; rx_byte_i = 8'h01;
        @(negedge clk); rx_byte_i = 8'h08;
        @(negedge clk); rx_valid_i = 0; frame_end_i = 1; hw_lock_n_i = 1'b1;
        @(negedge clk); frame_end_i = 0; hw_lock_n_i = 1'b0;
        check("R9 pin level at frame end", stat_o, 8'h08);
        hw_lock_n_i = 1'b1;
    endtask

    task automatic t_short_long;
        frame(1, 8'h50, 0, 0, 1'b1);
        frame(1, 8'h01, 0, 0, 1'b1);
        check("R10 no data byte", stat_o, 8'h08);
        frame(1, 8'h50, 0, 0, 1'b1);
        frame(3, 8'h01, 8'h04, 8'h8C, 1'b1);
        check("R10 extra bytes ignored", stat_o, 8'h04);
    endtask

    task automatic probe(input logic [7:0] d, input logic [16:0] a, input logic exp);
        query_addr_i = a;
        #1 check($sformatf("R11 zone %0h addr %0h", d[3:2], a), query_prot_o, exp);
    endtask

    task automatic t_zones;
        armed_write(8'h00, 1'b1);
        probe(8'h00, 17'h00000, 0); probe(8'h00, 17'h1FFFF, 0);
        armed_write(8'h04, 1'b1);
        probe(8'h04, 17'h17FFF, 0); probe(8'h04, 17'h18000, 1); probe(8'h04, 17'h1FFFF, 1);
        armed_write(8'h08, 1'b1);
        probe(8'h08, 17'h0FFFF, 0); probe(8'h08, 17'h10000, 1); probe(8'h08, 17'h18000, 1);
        armed_write(8'h0C, 1'b1);
        probe(8'h0C, 17'h00000, 1); probe(8'h0C, 17'h0FFFF, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mirror();
        t_unarmed();
        t_arm_lost();
        t_write_open();
        t_lock();
        t_pin_sample();
        t_short_long();
        t_zones();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule